// File: doc/BRIEF.md
# Multiple-Register Transfer Address Sequencer

This block steps through a block transfer of several registers to or from memory. A one-cycle start pulse carries a base address, a 16-bit mask that selects registers, an addressing mode, a load/store flag and a writeback request. From the next cycle the block issues one word transfer per cycle. Each transfer carries a memory address, the 4-bit index of the register involved and the direction. Registers are visited from the lowest index to the highest. Addresses always rise by one word per transfer, so the lowest-numbered register meets the lowest address in every mode.

Four addressing modes are supported: step up after each word, step up before each word, step down after each word and step down before each word. A small stack input can replace the explicit mode. It takes a growth direction (descending or ascending), a pointer convention (full or empty) and the direction of the transfer, picks the matching mode and forces writeback. When the sequence ends, a one-cycle completion pulse carries either the base value to write back or an alignment fault. On a fault no transfer is issued.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, busy, xfer_valid, done, fault and wb_valid are all low.
- R2: A run issues exactly one transfer per set mask bit, one per cycle, in strictly ascending register index. xfer_load repeats the is_load value captured at start. The first transfer appears in the cycle after the accepting clock edge.
- R3: With mode code 0 (step up after), the first address is the base. With mode code 1 (step up before), the first address is base+4. Each later transfer adds 4.
- R4: With mode code 2 (step down after), the first address is base-4·n+4. With mode code 3 (step down before), it is base-4·n. Here n is the number of set mask bits, and each later transfer adds 4.
- R5: wb_valid is high only in the done cycle and only when writeback was requested. wb_value is then base+4·n for modes 0 and 1, and base-4·n for modes 2 and 3.
- R6: With stack_en high, the mode comes from stack_desc (1 = descending), stack_full (1 = full) and is_load, and writeback is forced on. The mapping is: full-descending store→3, load→0; empty-descending store→2, load→1; full-ascending store→1, load→2; empty-ascending store→0, load→3.
- R7: An all-zero mask issues no transfer. done rises in the cycle after start, and wb_value equals the base when writeback is requested.
- R8: A base whose two low bits are not zero raises fault together with done in the cycle after start. It issues no transfer and wb_valid stays low.
- R9: busy is high from the cycle after start through the single done cycle and low after it. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| start | input | 1 | Begin a sequence (accepted only while idle) |
| base_addr | input | 32 | Base address |
| reg_mask | input | 16 | One bit per register to transfer |
| addr_mode | input | 2 | 0 up-after, 1 up-before, 2 down-after, 3 down-before |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| wb_req | input | 1 | Request base writeback |
| stack_en | input | 1 | Derive mode from the stack inputs, force writeback |
| stack_desc | input | 1 | Stack grows downward when 1 |
| stack_full | input | 1 | Stack pointer addresses last item when 1 |
| busy | output | 1 | Sequence in progress |
| xfer_valid | output | 1 | A word transfer is issued this cycle |
| xfer_addr | output | 32 | Word address of the transfer |
| xfer_idx | output | 4 | Register index of the transfer |
| xfer_load | output | 1 | Direction of the transfer |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Alignment fault, with done |
| wb_valid | output | 1 | wb_value should be written to the base register |
| wb_value | output | 32 | Final base value |

## Verification
Each of the four explicit modes runs with a different sparse or full mask. A wrong sign, a missing one-word offset or a reversed walking order then shows up as a distinct wrong address. Four stack combinations, covering both directions and both pointer conventions, are run with writeback deliberately not requested. This separates a wrong mode mapping from a forgotten forced writeback. An empty mask, a misaligned base and a start pulse injected mid-run cover the early-completion, fault and busy-ignore paths.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    AM_UP_AFTER   = 2'd0,
    AM_UP_BEFORE  = 2'd1,
    AM_DN_AFTER   = 2'd2,
    AM_DN_BEFORE  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  // Stack convention to addressing mode; a store is a push, a load a pop.
  function automatic amode_e stack_to_mode(input logic desc, input logic full,
                                           input logic pop);
    amode_e m;
    if (!pop) begin
      if (desc) m = full ? AM_DN_BEFORE : AM_DN_AFTER;
      else      m = full ? AM_UP_BEFORE : AM_UP_AFTER;
    end else begin
      if (desc) m = full ? AM_UP_AFTER  : AM_UP_BEFORE;
      else      m = full ? AM_DN_AFTER  : AM_DN_BEFORE;
    end
    return m;
  endfunction

endpackage

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
  parameter int NREGS = 16,
  localparam int IDX_W = $clog2(NREGS),
  localparam int CNT_W = $clog2(NREGS + 1)
) (
  input  logic [NREGS-1:0] mask,
  output logic [IDX_W-1:0] lo_idx,
  output logic [CNT_W-1:0] cnt
);

  always_comb begin
    lo_idx = '0;
    cnt    = '0;
    for (int i = NREGS - 1; i >= 0; i--) begin
      if (mask[i]) lo_idx = IDX_W'(i);
      cnt = cnt + CNT_W'(mask[i]);
    end
  end

endmodule

// File: rtl/blkxfer_plan.sv
module blkxfer_plan
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREGS      = 16,
  parameter int WORD_BYTES = 4,
  localparam int CNT_W = $clog2(NREGS + 1)
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  input  amode_e            mode,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] final_base
);

  function automatic logic [ADDR_W-1:0] span_of(input logic [CNT_W-1:0] n);
    return ADDR_W'(n) * ADDR_W'(WORD_BYTES);
  endfunction

  function automatic logic [ADDR_W-1:0] start_of(input logic [ADDR_W-1:0] b,
                                                 input logic [ADDR_W-1:0] s,
                                                 input amode_e m);
    logic [ADDR_W-1:0] w;
    w = ADDR_W'(WORD_BYTES);
    case (m)
      AM_UP_AFTER:  return b;
      AM_UP_BEFORE: return b + w;
      AM_DN_AFTER:  return b - s + w;
      default:      return b - s;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] end_of(input logic [ADDR_W-1:0] b,
                                               input logic [ADDR_W-1:0] s,
                                               input amode_e m);
    return (m == AM_UP_AFTER || m == AM_UP_BEFORE) ? b + s : b - s;
  endfunction

  logic [ADDR_W-1:0] span;
  assign span       = span_of(count);
  assign first_addr = start_of(base, span, mode);
  assign final_base = end_of(base, span, mode);

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREGS      = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W   = $clog2(NREGS),
  localparam int CNT_W   = $clog2(NREGS + 1),
  localparam int ALIGN_W = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [NREGS-1:0]  reg_mask,
  input  logic [1:0]        addr_mode,
  input  logic              is_load,
  input  logic              wb_req,
  input  logic              stack_en,
  input  logic              stack_desc,
  input  logic              stack_full,
  output logic              busy,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [IDX_W-1:0]  xfer_idx,
  output logic              xfer_load,
  output logic              done,
  output logic              fault,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_value
);

  seq_state_e        st_q;
  logic [NREGS-1:0]  rem_q;
  logic [ADDR_W-1:0] cur_q, fin_q;
  logic              wb_q, load_q, fault_q;

  logic [IDX_W-1:0]  in_lo_unused, lo_idx;
  logic [CNT_W-1:0]  in_cnt, rem_cnt;
  logic [ADDR_W-1:0] first_a, final_a;
  amode_e            eff_mode;
  logic              eff_wb, misalign;

  // Named internal events for the assertions.
  logic accept_evt, step_evt, last_step_evt, short_evt;

  blkxfer_pick #(.NREGS(NREGS)) u_in_pick (
    .mask(reg_mask), .lo_idx(in_lo_unused), .cnt(in_cnt)
  );

  blkxfer_pick #(.NREGS(NREGS)) u_rem_pick (
    .mask(rem_q), .lo_idx(lo_idx), .cnt(rem_cnt)
  );

  assign eff_mode = stack_en ? stack_to_mode(stack_desc, stack_full, is_load)
                             : amode_e'(addr_mode);
  assign eff_wb   = stack_en | wb_req;
  assign misalign = |base_addr[ALIGN_W-1:0];

  blkxfer_plan #(.ADDR_W(ADDR_W), .NREGS(NREGS), .WORD_BYTES(WORD_BYTES)) u_plan (
    .base(base_addr), .count(in_cnt), .mode(eff_mode),
    .first_addr(first_a), .final_base(final_a)
  );

  assign accept_evt    = start && (st_q == ST_IDLE);
  assign short_evt     = accept_evt && (misalign || in_cnt == '0);
  assign step_evt      = (st_q == ST_RUN);
  assign last_step_evt = step_evt && (rem_cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rem_q   <= '0;
      cur_q   <= '0;
      fin_q   <= '0;
      wb_q    <= 1'b0;
      load_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept_evt) begin
          rem_q   <= reg_mask;
          cur_q   <= first_a;
          fin_q   <= final_a;
          wb_q    <= eff_wb;
          load_q  <= is_load;
          fault_q <= misalign;
          st_q    <= short_evt ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          rem_q <= rem_q & ~(NREGS'(1) << lo_idx);
          cur_q <= cur_q + ADDR_W'(WORD_BYTES);
          if (last_step_evt) st_q <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign xfer_valid = step_evt;
  assign xfer_addr  = cur_q;
  assign xfer_idx   = lo_idx;
  assign xfer_load  = load_q;
  assign done       = (st_q == ST_FIN);
  assign fault      = done && fault_q;
  assign wb_valid   = done && wb_q && !fault_q;
  assign wb_value   = fin_q;

  // Transfers never happen outside a busy window.
  p_xfer_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> busy);

  // Completion is a single-cycle pulse.
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // Back-to-back transfers step the address by one word.
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_valid) && xfer_valid) |-> xfer_addr == $past(xfer_addr) + ADDR_W'(WORD_BYTES));

  // Back-to-back transfers visit strictly higher register indices.
  p_idx_rising_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_valid) && xfer_valid) |-> xfer_idx > $past(xfer_idx));

  // A fault comes with no transfer and no writeback.
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!wb_valid && !xfer_valid));

  // The last transfer is followed by the completion pulse.
  p_last_then_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_step_evt |=> done);

  // A misaligned or empty request completes on the next cycle.
  p_short_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    short_evt |=> (done && !xfer_valid));

endmodule

// File: tb/blkxfer_seq_bench.sv
module blkxfer_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_mask = '0;
  logic [1:0]  addr_mode = '0;
  logic        is_load = 1'b0, wb_req = 1'b0;
  logic        stack_en = 1'b0, stack_desc = 1'b0, stack_full = 1'b0;
  logic        busy, xfer_valid, xfer_load, done, fault, wb_valid;
  logic [31:0] xfer_addr, wb_value;
  logic [3:0]  xfer_idx;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  blkxfer_seq u_blkxfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .reg_mask(reg_mask), .addr_mode(addr_mode), .is_load(is_load),
    .wb_req(wb_req), .stack_en(stack_en), .stack_desc(stack_desc),
    .stack_full(stack_full), .busy(busy), .xfer_valid(xfer_valid),
    .xfer_addr(xfer_addr), .xfer_idx(xfer_idx), .xfer_load(xfer_load),
    .done(done), .fault(fault), .wb_valid(wb_valid), .wb_value(wb_value)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One scenario: exp_md is the mode the requirements call for.
  task automatic run_case(input string tag, input logic [31:0] b,
                          input logic [15:0] m, input logic [1:0] md,
                          input logic ld, input logic wb, input logic sen,
                          input logic sd, input logic sf,
                          input logic [1:0] exp_md, input logic exp_wb,
                          input logic poke);
    int n = 0;
    logic [31:0] a, fin;
    logic misal;
    bit first = 1'b1;
    for (int i = 0; i < 16; i++) n += int'(m[i]);
    misal = (b[1:0] != 2'b00);
    case (exp_md)
      2'd0: begin a = b;              fin = b + 32'(4 * n); end
      2'd1: begin a = b + 4;          fin = b + 32'(4 * n); end
      2'd2: begin a = b - 32'(4 * n) + 4; fin = b - 32'(4 * n); end
      default: begin a = b - 32'(4 * n); fin = b - 32'(4 * n); end
    endcase
    base_addr = b; reg_mask = m; addr_mode = md; is_load = ld; wb_req = wb;
    stack_en = sen; stack_desc = sd; stack_full = sf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!misal) begin
      for (int i = 0; i < 16; i++) begin
        if (m[i]) begin
          chk(xfer_valid === 1'b1, {tag, " R2 valid"}, 32'(xfer_valid), 32'd1);
          chk(busy === 1'b1, {tag, " R9 busy"}, 32'(busy), 32'd1);
          chk(xfer_idx === 4'(i), {tag, " R2 idx"}, 32'(xfer_idx), 32'(i));
          chk(xfer_addr === a, {tag, " R3/R4 addr"}, xfer_addr, a);
          chk(xfer_load === ld, {tag, " R2 dir"}, 32'(xfer_load), 32'(ld));
          a = a + 4;
          if (poke && first) begin
            start = 1'b1; reg_mask = 16'hFFFF; base_addr = 32'h0000_0003;
          end else start = 1'b0;
          first = 1'b0;
          @(negedge clk);
        end
      end
      start = 1'b0;
    end
    chk(done === 1'b1 && xfer_valid === 1'b0, {tag, " R2 done"}, 32'(done), 32'd1);
    chk(fault === misal, {tag, " R8 fault"}, 32'(fault), 32'(misal));
    chk(wb_valid === (exp_wb && !misal), {tag, " R5 wb_valid"}, 32'(wb_valid),
        32'(exp_wb && !misal));
    if (exp_wb && !misal)
      chk(wb_value === fin, {tag, " R5 wb_value"}, wb_value, fin);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && xfer_valid === 1'b0, {tag, " R9 idle"},
        {29'd0, busy, done, xfer_valid}, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && xfer_valid === 0 && done === 0 && fault === 0 && wb_valid === 0,
        "R1 reset", {27'd0, busy, xfer_valid, done, fault, wb_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // Explicit modes R3 R4 R5
    run_case("up_after",   32'h0000_1000, 16'h0A35, 2'd0, 1'b0, 1'b1, 0, 0, 0, 2'd0, 1'b1, 1'b0);
    run_case("up_before",  32'h0000_2000, 16'h8001, 2'd1, 1'b1, 1'b0, 0, 0, 0, 2'd1, 1'b0, 1'b0);
    run_case("dn_after",   32'h0000_3000, 16'h00F0, 2'd2, 1'b0, 1'b1, 0, 0, 0, 2'd2, 1'b1, 1'b0);
    run_case("dn_before",  32'h0000_4000, 16'hFFFF, 2'd3, 1'b1, 1'b1, 0, 0, 0, 2'd3, 1'b1, 1'b0);
    // Stack mapping R6: writeback not requested but forced
    run_case("fd_push", 32'h0000_5000, 16'h4011, 2'd0, 1'b0, 1'b0, 1, 1, 1, 2'd3, 1'b1, 1'b0);
    run_case("fd_pop",  32'h0000_5000, 16'h4011, 2'd3, 1'b1, 1'b0, 1, 1, 1, 2'd0, 1'b1, 1'b0);
    run_case("ed_pop",  32'h0000_5100, 16'h0006, 2'd0, 1'b1, 1'b0, 1, 1, 0, 2'd1, 1'b1, 1'b0);
    run_case("fa_pop",  32'h0000_5200, 16'h0300, 2'd0, 1'b1, 1'b0, 1, 0, 1, 2'd2, 1'b1, 1'b0);
    run_case("ea_push", 32'h0000_5300, 16'h1001, 2'd3, 1'b0, 1'b0, 1, 0, 0, 2'd0, 1'b1, 1'b0);
    // R7 empty mask
    run_case("empty", 32'h0000_6000, 16'h0000, 2'd3, 1'b0, 1'b1, 0, 0, 0, 2'd3, 1'b1, 1'b0);
    // R8 misaligned base
    run_case("misalign", 32'h0000_7002, 16'h0003, 2'd0, 1'b1, 1'b1, 0, 0, 0, 2'd0, 1'b1, 1'b0);
    // R9 start while busy ignored
    run_case("poke", 32'h0000_8000, 16'h0124, 2'd1, 1'b0, 1'b1, 0, 0, 0, 2'd1, 1'b1, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule